// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers up to 32 interrupt requests and presents one request line to the processor core. Each request input passes through a synchroniser. A rising edge on the synchronised input latches a status bit. Software clears that bit by writing a one to it. A separate enable register selects which latched requests may interrupt the core. The pending set is the bitwise AND of status and enable. A priority encoder picks one pending source and reports its number. When nothing is pending, it reports the value 32.

Sources are numbered from the most significant bit down. Source n sits in bit 31-n of every register, and a lower number means a higher priority. Only some positions are wired to real request sources. A parameter mask selects them: by default sources 0 to 13, which covers six external pins and eight internal peripheral requests. The other positions never latch and always read as zero. The register bus has a write port and a read port, each with its own address. Reads are combinational from the stored state.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source n (0..31) occupies bit 31-n of the status register (read address 0) and of the enable register (read/write address 1). Reads of address 0 return the stored status without the enable mask applied.
- R2: A request input that was sampled low at one clock edge and high at the next edge k latches its status bit so that it is readable after edge k+2. A request that stays high sets its bit only once, so once cleared the bit stays clear.
- R3: A write to address 0 clears each status bit whose data bit is one and leaves bits whose data bit is zero unchanged.
- R4: If a status bit is set by a request edge in the same cycle that a write to address 0 clears it, the bit ends up set.
- R5: Reset is synchronous and active high. After reset, status and enable are all zero, and a write to address 1 loads the enable register.
- R6: Read address 2 returns in bits [5:0] the lowest-numbered source whose status and enable bits are both one. Bits [31:6] read as zero.
- R7: When status AND enable is zero, read address 2 returns 32.
- R8: The output irq_o is registered. After each edge it equals the OR of status AND enable as they stood before that edge.
- R9: Positions that are clear in IMPL_MASK (by default sources 14..31, bits 17..0) never set in status or in enable and read as zero.
- R10: Writes to addresses 2 and 3 change nothing. Read address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 32 | Raw request inputs, source n on bit 31-n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 status clear, 1 enable) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address (0 status, 1 enable, 2 number, 3 zero) |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Registered interrupt request to the core |

## Verification
A request edge sampled at edge k shows up in the status and number reads after edge k+2. It reaches irq_o after edge k+3. A write shows up in the reads after the edge that captures it, and in irq_o one edge later. The bench drives every input at the falling edge. Its behavioural model replays sampled requests through a history of past samples and updates its state at each rising edge. Reads and irq_o are compared at the falling edge, half a period after the edge that produced them. The directed checks for the set-versus-clear collision and for the two-edge latency are placed on the exact cycle at which each effect is due.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int unsigned SRC_COUNT = 32;
    localparam int unsigned ID_W      = $clog2(SRC_COUNT);
    localparam int unsigned NUM_W     = ID_W + 1;

    typedef logic [SRC_COUNT-1:0] src_vec_t;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_NUMBER = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    // Packs to the readable number: none=1 gives the value SRC_COUNT.
    typedef struct packed {
        logic            none;
        logic [ID_W-1:0] src;
    } enc_res_t;

    function automatic enc_res_t first_pending(src_vec_t p);
        enc_res_t res;
        res.none = 1'b1;
        res.src  = '0;
        for (int n = SRC_COUNT - 1; n >= 0; n--) begin
            if (p[SRC_COUNT-1-n]) begin
                res.none = 1'b0;
                res.src  = ID_W'(n);
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/pic_sync_edge.sv
module pic_sync_edge #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] req_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [STAGES:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], req_i};
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter src_vec_t IMPL_MASK = 32'hFFFC_0000
) (
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_i,
    input  logic     wr_en,
    input  reg_sel_e wr_sel,
    input  src_vec_t wr_data,
    output src_vec_t status_o,
    output src_vec_t enable_o
);
    src_vec_t status_q, enable_q, clr_vec;

    assign clr_vec = (wr_en && wr_sel == SEL_STATUS) ? wr_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= ((status_q & ~clr_vec) | set_i) & IMPL_MASK;
            if (wr_en && wr_sel == SEL_ENABLE)
                enable_q <= wr_data & IMPL_MASK;
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc
    import pic_pkg::*;
(
    input  src_vec_t status_i,
    input  src_vec_t enable_i,
    output src_vec_t pending_o,
    output enc_res_t result_o
);
    assign pending_o = status_i & enable_i;
    assign result_o  = first_pending(pending_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [31:0] IMPL_MASK   = 32'hFFFC_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] req_i,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        irq_o
);
    src_vec_t set_vec, status, enable, pending;
    enc_res_t enc;
    logic     irq_q;

    pic_sync_edge #(.WIDTH(SRC_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .req_i(req_i), .rise_o(set_vec)
    );

    pic_regs #(.IMPL_MASK(IMPL_MASK)) u_regs (
        .clk(clk), .rst(rst), .set_i(set_vec),
        .wr_en(wr_en), .wr_sel(reg_sel_e'(wr_addr)), .wr_data(wr_data),
        .status_o(status), .enable_o(enable)
    );

    pic_prio_enc u_enc (
        .status_i(status), .enable_i(enable),
        .pending_o(pending), .result_o(enc)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |pending;
    end
    assign irq_o = irq_q;

    always_comb begin
        unique case (reg_sel_e'(rd_addr))
            SEL_STATUS: rd_data = status;
            SEL_ENABLE: rd_data = enable;
            SEL_NUMBER: rd_data = {{(32-NUM_W){1'b0}}, enc};
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter logic [31:0] IMPL_MASK = 32'hFFFC_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic [31:0] set_vec,
    input logic [31:0] status,
    input logic [31:0] enable,
    input logic [5:0]  number,
    input logic        irq_o
);
    logic [31:0] pend;
    assign pend = status & enable;

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (rst)
        (|pend) |=> irq_o);
    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !(|pend) |=> !irq_o);
    assert_reset_clear_R5: assert property (@(posedge clk)
        $past(rst) |-> (status == '0 && enable == '0 && !irq_o));
    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0) |=>
        ((status & $past(wr_data) & ~$past(set_vec)) == '0));
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (|(set_vec & IMPL_MASK)) |=> ((status & $past(set_vec) & IMPL_MASK) == ($past(set_vec) & IMPL_MASK)));
    assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (rst)
        ((status | enable) & ~IMPL_MASK) == '0);
    assert_none_R7: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> (number == 6'd32));
    assert_winner_R6: assert property (@(posedge clk) disable iff (rst)
        (pend != '0) |-> (number < 6'd32 && pend[5'd31 - number[4:0]]
                          && (32'(pend >> (6'd32 - number)) == '0)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.IMPL_MASK(IMPL_MASK)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .set_vec(set_vec), .status(status), .enable(enable),
    .number(enc), .irq_o(irq_o)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
    localparam logic [31:0] IMPL = 32'hFFFC_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] req_i = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst(rst), .req_i(req_i), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    // Behavioural reference: history of sampled requests, model registers.
    logic [31:0] samp [0:3];
    logic [31:0] m_status = '0, m_enable = '0;
    logic        m_irq = 1'b0;

    function automatic logic [31:0] src_bit(int n);
        return 32'h8000_0000 >> n;
    endfunction

    function automatic logic [31:0] m_number();
        logic [31:0] p = m_status & m_enable;
        for (int n = 0; n < 32; n++)
            if ((p & src_bit(n)) != 0) return n;
        return 32;
    endfunction

    initial for (int i = 0; i < 4; i++) samp[i] = '0;

    always @(posedge clk) begin
        logic [31:0] newly, wipe;
        for (int i = 3; i > 0; i--) samp[i] = samp[i-1];
        samp[0] = req_i;
        if (rst) begin
            m_status = '0; m_enable = '0; m_irq = 1'b0;
            for (int i = 0; i < 4; i++) samp[i] = '0;
            samp[0] = req_i;
        end else begin
            m_irq  = ((m_status & m_enable) != 0);
            newly  = samp[2] & ~samp[3];
            wipe   = (wr_en && wr_addr == 2'd0) ? wr_data : '0;
            m_status = ((m_status & ~wipe) | newly) & IMPL;
            if (wr_en && wr_addr == 2'd1) m_enable = wr_data & IMPL;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (irq_o !== m_irq) begin
                failures++;
                $display("FAIL R8 irq_o actual=%0b expected=%0b", irq_o, m_irq);
            end
        end
    end

    task automatic check_val(input logic [1:0] a, input logic [31:0] exp, input string tag);
        rd_addr = a;
        #0.5;
        checks++;
        if (rd_data !== exp) begin
            failures++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rd_data, exp);
        end
    endtask

    task automatic check_model(input string tag);
        check_val(2'd0, m_status, tag);
        check_val(2'd1, m_enable, tag);
        check_val(2'd2, m_number(), tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5 R7: reset state
        check_val(2'd0, 32'h0, "R5 status after reset");
        check_val(2'd1, 32'h0, "R5 enable after reset");
        check_val(2'd2, 32'd32, "R7 none pending after reset");
        // R5 R9: enable load, unimplemented bits read zero
        wr(2'd1, 32'hFFFF_FFFF);
        check_val(2'd1, IMPL, "R9 enable unimplemented bits");

        // R2: latency of a request edge (source 5 = bit 26)
        req_i = src_bit(5);
        @(negedge clk);                         // edge k sampled it
        @(negedge clk);                         // after k+1
        check_val(2'd0, 32'h0, "R2 not yet latched");
        @(negedge clk);                         // after k+2
        check_val(2'd0, 32'h0400_0000, "R2 latched source 5 R1");
        check_val(2'd2, 32'd5, "R6 number source 5");
        @(negedge clk);
        checks++;
        if (irq_o !== 1'b1) begin
            failures++;
            $display("FAIL R8 irq_o actual=%0b expected=1", irq_o);
        end

        // R6 R9: priority among several, with an unimplemented source 20
        req_i = src_bit(5) | src_bit(2) | src_bit(13) | src_bit(20);
        repeat (3) @(negedge clk);
        check_val(2'd0, src_bit(2) | src_bit(5) | src_bit(13), "R9 status excludes 20");
        check_val(2'd2, 32'd2, "R6 source 2 wins");

        // R3: clear source 2, zero write leaves all
        wr(2'd0, src_bit(2));
        check_val(2'd2, 32'd5, "R3 cleared source 2");
        wr(2'd0, 32'h0);
        check_val(2'd0, src_bit(5) | src_bit(13), "R3 zeros keep bits");

        // R2: held request does not re-set after clear
        wr(2'd0, src_bit(5));
        repeat (4) @(negedge clk);
        check_val(2'd0, src_bit(13), "R2 held request stays cleared");

        // R6 R7: enable masks
        wr(2'd1, src_bit(5) | src_bit(0));
        check_val(2'd2, 32'd32, "R7 status not enabled");
        wr(2'd1, src_bit(13));
        check_val(2'd2, 32'd13, "R6 source 13 via enable");
        wr(2'd1, 32'h0);
        check_val(2'd2, 32'd32, "R7 all disabled");

        // R4: set and clear collide on source 7
        req_i = 32'h0;
        repeat (3) @(negedge clk);
        req_i = src_bit(7);
        @(negedge clk);                         // after edge k
        @(negedge clk);                         // after k+1
        wr(2'd0, src_bit(7));                   // captured at k+2
        check_val(2'd0, src_bit(7) | src_bit(13), "R4 set wins over clear");

        // R10: writes to addresses 2 and 3 ignored
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        check_val(2'd0, src_bit(7) | src_bit(13), "R10 status untouched");
        check_val(2'd1, 32'h0, "R10 enable untouched");
        check_val(2'd3, 32'h0, "R10 spare reads zero");

        // Mixed traffic against the model
        for (int c = 0; c < 400; c++) begin
            req_i = $urandom();
            if ($urandom_range(0, 3) == 0) wr(2'($urandom_range(0, 3)), $urandom());
            else @(negedge clk);
            if (c % 8 == 0) check_model("R1 R6 model");
        end

        // R5: synchronous reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_val(2'd0, 32'h0, "R5 status after reset");
        check_val(2'd1, 32'h0, "R5 enable after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule